// File: doc/BRIEF.md
# Deferred Integer Condition-Code Unit

This block sits beside an integer ALU and removes condition-code arithmetic from the ALU's critical path. When an operation that sets flags retires, the ALU hands over the operation kind, both source operands and the result. The unit only records them. The N, Z, V and C flags are worked out from the recorded values when something reads them. Two flag sets are produced side by side. The narrow set uses the low 32 bits of the operands. The extended set uses the full 64 bits.

Each set is presented as a 4-bit field packed `{N,Z,V,C}`. A materialize strobe writes both computed sets into stored flag registers and puts the unit into the "flags valid" state. In that state, reads return the stored values. A separate carry query returns the narrow-set carry as a single bit and leaves all state unchanged. All strobes are plain single-cycle controls with no back-pressure. A capture is accepted in every cycle in which its strobe is high. The flag outputs are valid in every cycle.

Top module: `lazy_cc_unit`

## Requirements
- R1: In both sets, Z is 1 exactly when the result (its low 32 bits for the narrow set, all 64 bits for the extended set) is zero, and N equals the sign bit of that result. N and Z are never 1 together.
- R2: Kind code 3 (add) sets C when the result is unsigned-below src1. Its V is the top bit of `~(s1^s2) & (s1^res)`. Kind code 4 (add with carry-in) uses the same V, and its C is the top bit of `(s1&s2) | (~res&(s1|s2))`.
- R3: Kind code 7 (subtract) sets C when src1 is unsigned-below src2. Its V is the top bit of `(s1^s2) & (s1^res)`. Kind code 8 (subtract with borrow) uses the same V, and its C is the top bit of `(~s1&s2) | (res&(~s1|s2))`.
- R4: In the narrow set, kind codes 5 (tagged add) and 9 (tagged subtract) follow the rules of codes 3 and 7. In addition, they force V to 1 when bits [1:0] of either operand are nonzero.
- R5: In the narrow set, kind codes 6 (trapping tagged add) and 10 (trapping tagged subtract) report N, Z and the add or subtract C, with V forced to 0.
- R6: In the extended set, kind codes 5 and 6 follow the 64-bit add rules and codes 9 and 10 follow the 64-bit subtract rules. No tag check is applied.
- R7: Kind code 2 (divide): the narrow set takes N and Z from the result, sets V when the 64-bit src2 is nonzero, and forces C to 0. The extended set reports only N and Z.
- R8: Kind code 1 (logic) reports N and Z in both sets, with V and C at 0.
- R9: The cycle after a capture, both outputs show the flags of the captured operation. With no capture and no materialize, the outputs hold steady.
- R10: Kind code 0 and the unused codes 11 to 15 mean "flags valid": reads return the stored sets. A materialize stores both computed sets and selects this state, so the outputs are unchanged on the next cycle.
- R11: While `cc_carry_req` is high, `carry_bit` equals the C of the narrow set for the pending state. While it is low, `carry_bit` is 0. The query changes no state.
- R12: After reset the unit is in the "flags valid" state and both stored sets are zero.
- R13: When capture and materialize occur in the same cycle, the stored sets take the flags of the previously pending operation and the new capture becomes the pending one. A later capture with code 0 exposes the stored sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_rec | input | 1 | Record a flag-setting operation |
| op_kind | input | 4 | Operation kind code |
| op_src1 | input | 64 | First source operand |
| op_src2 | input | 64 | Second source operand |
| op_res | input | 64 | Operation result |
| cc_commit | input | 1 | Materialize computed flags into storage |
| cc_carry_req | input | 1 | Carry-only query |
| icc_nzvc | output | 4 | Narrow flag set {N,Z,V,C} |
| xcc_nzvc | output | 4 | Extended flag set {N,Z,V,C} |
| carry_bit | output | 1 | Narrow carry while queried |

## Verification
The stored flag sets are hard to observe at the ports. They only become visible while the unit is in the "flags valid" state, and a materialize in that state simply rewrites them with themselves. To expose them, the stimulus commits a pending operation, sometimes in the same cycle as a new capture. It then records kind code 0, which switches the outputs to the stored values and so shows which operation's flags were kept. Random cycles mix captures, commits and both together. The results are a blend of true sums, true differences, zero and unrelated values, so that every flag takes both polarities.

// File: rtl/lazycc_pkg.sv
package lazycc_pkg;
  localparam int XLEN = 64;
  localparam int NLEN = 32;

  typedef enum logic [3:0] {
    K_FLAGS = 4'd0,
    K_LOGIC = 4'd1,
    K_DIV   = 4'd2,
    K_ADD   = 4'd3,
    K_ADDC  = 4'd4,
    K_TADD  = 4'd5,
    K_TADDT = 4'd6,
    K_SUB   = 4'd7,
    K_SUBB  = 4'd8,
    K_TSUB  = 4'd9,
    K_TSUBT = 4'd10
  } kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/lazycc_terms.sv
module lazycc_terms #(
  parameter int W = 32
) (
  input  logic [W-1:0] s1,
  input  logic [W-1:0] s2,
  input  logic [W-1:0] res,
  output logic         neg,
  output logic         zero,
  output logic         c_add,
  output logic         c_addc,
  output logic         v_add,
  output logic         c_sub,
  output logic         c_subb,
  output logic         v_sub
);
  localparam int MSB = W - 1;

  logic [W-1:0] addc_vec, subb_vec, vadd_vec, vsub_vec;

  always_comb begin
    addc_vec = (s1 & s2) | (~res & (s1 | s2));
    subb_vec = (~s1 & s2) | (res & (~s1 | s2));
    vadd_vec = ~(s1 ^ s2) & (s1 ^ res);
    vsub_vec = (s1 ^ s2) & (s1 ^ res);
  end

  assign zero   = (res == '0);
  assign neg    = res[MSB];
  assign c_add  = (res < s1);
  assign c_addc = addc_vec[MSB];
  assign v_add  = vadd_vec[MSB];
  assign c_sub  = (s1 < s2);
  assign c_subb = subb_vec[MSB];
  assign v_sub  = vsub_vec[MSB];
endmodule

// File: rtl/lazycc_flag_calc.sv
module lazycc_flag_calc
  import lazycc_pkg::*;
#(
  parameter int W   = 32,
  parameter bit EXT = 1'b0
) (
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] s1,
  input  logic [XLEN-1:0] s2,
  input  logic [XLEN-1:0] res,
  input  nzvc_t           stored,
  output nzvc_t           flags
);
  logic neg, zero, c_add, c_addc, v_add, c_sub, c_subb, v_sub;
  logic tag_bad, div_ovf;
  logic [3:0] eff_kind;

  lazycc_terms #(.W(W)) u_terms (
    .s1(s1[W-1:0]), .s2(s2[W-1:0]), .res(res[W-1:0]),
    .neg(neg), .zero(zero), .c_add(c_add), .c_addc(c_addc), .v_add(v_add),
    .c_sub(c_sub), .c_subb(c_subb), .v_sub(v_sub)
  );

  assign tag_bad = |(s1[1:0] | s2[1:0]);
  assign div_ovf = |s2;

  // The extended set folds tagged and divide kinds onto simpler rules.
  generate
    if (EXT) begin : g_ext_map
      always_comb begin
        case (kind)
          K_TADD, K_TADDT: eff_kind = K_ADD;
          K_TSUB, K_TSUBT: eff_kind = K_SUB;
          K_DIV:           eff_kind = K_LOGIC;
          default:         eff_kind = kind;
        endcase
      end
    end else begin : g_nar_map
      assign eff_kind = kind;
    end
  endgenerate

  always_comb begin
    flags   = '0;
    flags.n = neg & ~zero;
    flags.z = zero;
    case (eff_kind)
      K_LOGIC: ;
      K_DIV:   flags.v = div_ovf;
      K_ADD:   begin flags.c = c_add;  flags.v = v_add; end
      K_ADDC:  begin flags.c = c_addc; flags.v = v_add; end
      K_TADD:  begin flags.c = c_add;  flags.v = v_add | tag_bad; end
      K_TADDT: flags.c = c_add;
      K_SUB:   begin flags.c = c_sub;  flags.v = v_sub; end
      K_SUBB:  begin flags.c = c_subb; flags.v = v_sub; end
      K_TSUB:  begin flags.c = c_sub;  flags.v = v_sub | tag_bad; end
      K_TSUBT: flags.c = c_sub;
      default: flags = stored;
    endcase
  end
endmodule

// File: rtl/lazycc_state.sv
module lazycc_state
  import lazycc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rec,
  input  logic [3:0]      rec_kind,
  input  logic [XLEN-1:0] rec_s1,
  input  logic [XLEN-1:0] rec_s2,
  input  logic [XLEN-1:0] rec_res,
  input  logic            commit,
  input  nzvc_t           icc_new,
  input  nzvc_t           xcc_new,
  output logic [3:0]      kind_q,
  output logic [XLEN-1:0] s1_q,
  output logic [XLEN-1:0] s2_q,
  output logic [XLEN-1:0] res_q,
  output nzvc_t           icc_st_q,
  output nzvc_t           xcc_st_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q   <= K_FLAGS;
      s1_q     <= '0;
      s2_q     <= '0;
      res_q    <= '0;
      icc_st_q <= '0;
      xcc_st_q <= '0;
    end else begin
      if (commit) begin
        icc_st_q <= icc_new;
        xcc_st_q <= xcc_new;
      end
      // A capture replaces the pending state after the commit has been folded.
      if (rec) begin
        kind_q <= rec_kind;
        s1_q   <= rec_s1;
        s2_q   <= rec_s2;
        res_q  <= rec_res;
      end else if (commit) begin
        kind_q <= K_FLAGS;
      end
    end
  end
endmodule

// File: rtl/lazy_cc_unit.sv
module lazy_cc_unit
  import lazycc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_rec,
  input  logic [3:0]      op_kind,
  input  logic [XLEN-1:0] op_src1,
  input  logic [XLEN-1:0] op_src2,
  input  logic [XLEN-1:0] op_res,
  input  logic            cc_commit,
  input  logic            cc_carry_req,
  output logic [3:0]      icc_nzvc,
  output logic [3:0]      xcc_nzvc,
  output logic            carry_bit
);
  logic [3:0]      kind_q;
  logic [XLEN-1:0] s1_q, s2_q, res_q;
  nzvc_t           icc_st_q, xcc_st_q, icc_now, xcc_now;

  lazycc_state u_state (
    .clk(clk), .rst_n(rst_n),
    .rec(op_rec), .rec_kind(op_kind), .rec_s1(op_src1), .rec_s2(op_src2),
    .rec_res(op_res), .commit(cc_commit),
    .icc_new(icc_now), .xcc_new(xcc_now),
    .kind_q(kind_q), .s1_q(s1_q), .s2_q(s2_q), .res_q(res_q),
    .icc_st_q(icc_st_q), .xcc_st_q(xcc_st_q)
  );

  lazycc_flag_calc #(.W(NLEN), .EXT(1'b0)) u_icc (
    .kind(kind_q), .s1(s1_q), .s2(s2_q), .res(res_q),
    .stored(icc_st_q), .flags(icc_now)
  );

  lazycc_flag_calc #(.W(XLEN), .EXT(1'b1)) u_xcc (
    .kind(kind_q), .s1(s1_q), .s2(s2_q), .res(res_q),
    .stored(xcc_st_q), .flags(xcc_now)
  );

  assign icc_nzvc  = icc_now;
  assign xcc_nzvc  = xcc_now;
  assign carry_bit = cc_carry_req & icc_now.c;
endmodule

// File: rtl/lazycc_checker.sv
module lazycc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_rec,
  input logic [3:0] op_kind,
  input logic       cc_commit,
  input logic       cc_carry_req,
  input logic [3:0] icc_nzvc,
  input logic [3:0] xcc_nzvc,
  input logic       carry_bit
);
  assert_nz_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(icc_nzvc[3] & icc_nzvc[2]) && !(xcc_nzvc[3] & xcc_nzvc[2]));

  assert_trap_tag_no_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rec && (op_kind == 4'd6 || op_kind == 4'd10)) |=> (icc_nzvc[1] == 1'b0));

  assert_div_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rec && op_kind == 4'd2) |=> (icc_nzvc[0] == 1'b0 && xcc_nzvc[1:0] == 2'b00));

  assert_logic_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rec && op_kind == 4'd1) |=> (icc_nzvc[1:0] == 2'b00 && xcc_nzvc[1:0] == 2'b00));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_rec && !cc_commit) |=> ($stable(icc_nzvc) && $stable(xcc_nzvc)));

  assert_commit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_commit && !op_rec) |=> ($stable(icc_nzvc) && $stable(xcc_nzvc)));

  assert_carry_query_R11: assert property (@(posedge clk) disable iff (!rst_n)
    carry_bit == (cc_carry_req & icc_nzvc[0]));
endmodule

bind lazy_cc_unit lazycc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_rec(op_rec), .op_kind(op_kind),
  .cc_commit(cc_commit), .cc_carry_req(cc_carry_req),
  .icc_nzvc(icc_nzvc), .xcc_nzvc(xcc_nzvc), .carry_bit(carry_bit)
);

// File: tb/sim_lazy_cc_unit.sv
module sim_lazy_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_rec = 1'b0;
  logic [3:0]  op_kind = '0;
  logic [63:0] op_src1 = '0, op_src2 = '0, op_res = '0;
  logic        cc_commit = 1'b0;
  logic        cc_carry_req = 1'b0;
  logic [3:0]  icc_nzvc, xcc_nzvc;
  logic        carry_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the pending and stored state
  logic [3:0]  m_kind = 4'd0;
  logic [63:0] m_s1 = '0, m_s2 = '0, m_res = '0;
  logic [3:0]  m_sti = '0, m_stx = '0;

  always #2 clk = ~clk;

  lazy_cc_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_rec(op_rec), .op_kind(op_kind),
    .op_src1(op_src1), .op_src2(op_src2), .op_res(op_res),
    .cc_commit(cc_commit), .cc_carry_req(cc_carry_req),
    .icc_nzvc(icc_nzvc), .xcc_nzvc(xcc_nzvc), .carry_bit(carry_bit)
  );

  function automatic logic [3:0] model(input bit ext, input logic [3:0] k,
                                       input logic [63:0] a, input logic [63:0] b,
                                       input logic [63:0] r, input logic [3:0] st);
    int w;
    logic [63:0] msk, aa, bb, rr;
    logic n, z, ca, cac, va, cs, csb, vs, tg;
    w   = ext ? 64 : 32;
    msk = ext ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    aa = a & msk; bb = b & msk; rr = r & msk;
    z   = (rr == 0);
    n   = rr[w-1];
    ca  = rr < aa;
    cs  = aa < bb;
    cac = ((aa & bb) | (~rr & (aa | bb)) & msk) >> (w-1);
    csb = ((~aa & bb) | (rr & (~aa | bb)) & msk) >> (w-1);
    va  = ((~(aa ^ bb)) & (aa ^ rr) & msk) >> (w-1);
    vs  = ((aa ^ bb) & (aa ^ rr)) >> (w-1);
    tg  = (a[1:0] != 0) || (b[1:0] != 0);
    case (k)
      4'd1:  return {n, z, 2'b00};
      4'd2:  return ext ? {n, z, 2'b00} : {n, z, (b != 0), 1'b0};
      4'd3:  return {n, z, va, ca};
      4'd4:  return {n, z, va, cac};
      4'd5:  return ext ? {n, z, va, ca} : {n, z, va | tg, ca};
      4'd6:  return ext ? {n, z, va, ca} : {n, z, 1'b0, ca};
      4'd7:  return {n, z, vs, cs};
      4'd8:  return {n, z, vs, csb};
      4'd9:  return ext ? {n, z, vs, cs} : {n, z, vs | tg, cs};
      4'd10: return ext ? {n, z, vs, cs} : {n, z, 1'b0, cs};
      default: return st;
    endcase
  endfunction

  function automatic string req_of(input bit ext, input logic [3:0] k);
    case (k)
      4'd1: return "R8";
      4'd2: return "R7";
      4'd3, 4'd4: return "R2";
      4'd7, 4'd8: return "R3";
      4'd5, 4'd9: return ext ? "R6" : "R4";
      4'd6, 4'd10: return ext ? "R6" : "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Check outputs against the model, then drive one cycle of stimulus.
  task automatic step(input bit rec, input logic [3:0] k, input logic [63:0] a,
                      input logic [63:0] b, input logic [63:0] r,
                      input bit cm, input bit cq);
    logic [3:0] ei, ex;
    ei = model(1'b0, m_kind, m_s1, m_s2, m_res, m_sti);
    ex = model(1'b1, m_kind, m_s1, m_s2, m_res, m_stx);
    check(req_of(1'b0, m_kind), icc_nzvc, ei);
    check(req_of(1'b1, m_kind), xcc_nzvc, ex);
    op_rec = rec; op_kind = k; op_src1 = a; op_src2 = b; op_res = r;
    cc_commit = cm; cc_carry_req = cq;
    #1;
    check("R11", {3'b000, carry_bit}, {3'b000, cq & ei[0]});
    if (cm) begin m_sti = ei; m_stx = ex; end
    if (rec) begin m_kind = k; m_s1 = a; m_s2 = b; m_res = r; end
    else if (cm) m_kind = 4'd0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state is flags-valid with zero stored sets
    check("R12", icc_nzvc, 4'h0);
    check("R12", xcc_nzvc, 4'h0);

    // R1: zero result and negative result
    step(1, 4'd3, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 0);
    check("R1", icc_nzvc, 4'b0101);
    step(1, 4'd1, 64'h0, 64'h0, 64'h8000_0000_8000_0000, 0, 0);
    check("R1", icc_nzvc, 4'b1000);
    check("R1", xcc_nzvc, 4'b1000);
    // R2: signed overflow in the narrow set
    step(1, 4'd3, 64'h7FFF_FFFF, 64'h1, 64'h8000_0000, 0, 1);
    check("R2", icc_nzvc, 4'b1010);
    // R4 / R6: tagged add with tag bits set
    step(1, 4'd5, 64'h5, 64'h4, 64'h9, 0, 0);
    check("R4", icc_nzvc, 4'b0010);
    check("R6", xcc_nzvc, 4'b0000);
    // R7: divide with nonzero src2 above bit 31
    step(1, 4'd2, 64'h0, 64'h1_0000_0000, 64'h0, 0, 0);
    check("R7", icc_nzvc, 4'b0110);
    check("R7", xcc_nzvc, 4'b0100);
    // R3: borrow from subtract
    step(1, 4'd7, 64'h1, 64'h2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    check("R3", icc_nzvc, 4'b1001);
    // R10: commit then hold
    step(0, 4'd0, 0, 0, 0, 1, 1);
    check("R10", icc_nzvc, 4'b1001);
    step(0, 4'd0, 0, 0, 0, 0, 0);
    // R13: commit with simultaneous capture, then expose stored via code 0
    step(1, 4'd1, 64'h0, 64'h0, 64'h0, 0, 0);
    step(1, 4'd3, 64'h7FFF_FFFF, 64'h1, 64'h8000_0000, 1, 0);
    check("R13", icc_nzvc, 4'b1010);
    step(1, 4'd0, 0, 0, 0, 0, 0);
    check("R13", icc_nzvc, 4'b0100);
    step(0, 4'd0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b, r;
      logic [3:0]  k;
      int sel;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) a[63:32] = '0;
      if ($urandom_range(0, 7) == 0) b = '0;
      if ($urandom_range(0, 3) == 0) begin a[1:0] = 2'b00; b[1:0] = 2'b00; end
      sel = $urandom_range(0, 3);
      r = (sel == 0) ? a + b : (sel == 1) ? a - b : (sel == 2) ? 64'h0 : {$urandom(), $urandom()};
      k = 4'($urandom_range(0, 12));
      step($urandom_range(0, 2) != 0, k, a, b, r,
           $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule